// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 raw interrupt lines, qualifies each one by its own trigger mode, and steers it to one output line of one of four cores. Software sets a per-source route byte, a polarity bit and an edge bit, and switches sources on and off through two separate write ports. One port sets enable bits and the other clears them. The current enable mask can be read back.

Raw lines first pass a two-flop synchronizer. Edge-mode sources latch the detected edge until software clears it. Level-mode sources are pending for as long as the qualified level holds. Each core has a status register that lists its enabled, pending sources. A service routine reads that value, writes it to the disable port and then writes it to the enable port, which arms those sources again.

Top module: `lirq_router`

## Requirements
- R1: After reset the enable mask, polarity, edge and every route byte read 0, and all output lines are low.
- R2: Byte address n (0 to 31) holds the route byte of source n. A write stores wdata[7:0], and a read returns that byte in rdata[7:0] with zeros above it.
- R3: A write to address 0x20 sets each enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x20 returns the enable mask.
- R4: A write to address 0x24 clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R5: When the edge bit (address 0x2C) is 1 and the polarity bit (address 0x28) is 0, a 0-to-1 transition of the source makes it pending.
- R6: When the edge bit is 1 and the polarity bit is 1, a 1-to-0 transition of the source makes it pending, and a rising transition has no effect.
- R7: When the edge bit is 0 and the polarity bit is 1, the source is pending while its input is high.
- R8: When the edge bit is 0 and the polarity bit is 0, the source is pending while its input is low.
- R9: A latched edge stays pending after the input returns to its idle level. It is cleared only by writing a 1 to that source's bit in the disable port.
- R10: Reading address 0x30+4*c returns the enabled, pending sources whose route byte has core bit c set. In the route byte, bits [3:0] select the core one-hot and bits [7:4] select the line one-hot.
- R11: irq_o[4*c+l] is high exactly when at least one enabled, pending source has core bit c and line bit 4+l set. Several sources may drive the same line, and a disabled source drives none.
- R12: Writing a status value to the disable port and then to the enable port re-enables those sources with their latches cleared, so only a new edge raises the line again.
- R13: A level source reaches the outputs two clock edges after its input changes, and an edge source three clock edges after its input changes. A register write takes effect at the edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt source lines |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte address of the register port |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 16 | Core output lines, index 4*core+line |

## Verification
Register writes are checked at the falling edge that follows the capturing rising edge, because read data and outputs are combinational from the registers. After a source input changes, the bench checks level-mode results on the second falling edge. It checks edge-mode results on the third falling edge, and one falling edge earlier it confirms the line is still low, which pins the latency exactly. All inputs are driven at falling edges, so no sample competes with the rising edge.

// File: rtl/lirq_router.sv
module lirq_router #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4,
  parameter int AW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [NCORE*NLINE-1:0] irq_o
);
  localparam int RW  = NCORE + NLINE;
  localparam int SIW = $clog2(NSRC);
  localparam int CIW = $clog2(NCORE);
  localparam logic [AW-1:0] A_EN   = AW'(8'h20);
  localparam logic [AW-1:0] A_DIS  = AW'(8'h24);
  localparam logic [AW-1:0] A_POL  = AW'(8'h28);
  localparam logic [AW-1:0] A_EDGE = AW'(8'h2C);
  localparam logic [AW-1:0] A_STAT = AW'(8'h30);

  logic [RW-1:0]   route_q [NSRC];
  logic [NSRC-1:0] en_q, pol_q, edge_q, s1_q, s2_q, prev_q, lat_q;
  logic [NSRC-1:0] hit, level, act;
  logic [NSRC-1:0] core_sel [NCORE];
  logic [NSRC-1:0] line_sel [NLINE];
  logic [NSRC-1:0] stat [NCORE];

  wire wr_en   = we_i && addr_i == A_EN;
  wire wr_dis  = we_i && addr_i == A_DIS;
  wire wr_pol  = we_i && addr_i == A_POL;
  wire wr_edge = we_i && addr_i == A_EDGE;
  wire [NSRC-1:0] wv  = wdata_i[NSRC-1:0];
  wire [NSRC-1:0] clr = wr_dis ? wv : '0;

  assign hit   = edge_q & ((~pol_q & s2_q & ~prev_q) | (pol_q & ~s2_q & prev_q));
  assign level = ~edge_q & ~(s2_q ^ pol_q);
  assign act   = (lat_q | level) & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; pol_q <= '0; edge_q <= '0;
      s1_q <= '0; s2_q <= '0; prev_q <= '0; lat_q <= '0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      lat_q  <= edge_q & (lat_q | hit) & ~clr;
      if (wr_en)   en_q   <= en_q | wv;
      if (wr_dis)  en_q   <= en_q & ~wv;
      if (wr_pol)  pol_q  <= wv;
      if (wr_edge) edge_q <= wv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) route_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++)
        if (we_i && addr_i == AW'(i)) route_q[i] <= wdata_i[RW-1:0];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    for (genvar c = 0; c < NCORE; c++) begin : g_c
      assign core_sel[c][i] = route_q[i][c];
    end
    for (genvar l = 0; l < NLINE; l++) begin : g_l
      assign line_sel[l][i] = route_q[i][NCORE+l];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign stat[c] = act & core_sel[c];
    for (genvar l = 0; l < NLINE; l++) begin : g_line
      assign irq_o[c*NLINE+l] = |(stat[c] & line_sel[l]);
    end
    assert_line_has_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c*NLINE +: NLINE] != '0) |-> (stat[c] != '0));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < AW'(NSRC))
      rdata_o[RW-1:0] = route_q[addr_i[SIW-1:0]];
    else if (addr_i == A_EN)
      rdata_o[NSRC-1:0] = en_q;
    else if (addr_i == A_POL)
      rdata_o[NSRC-1:0] = pol_q;
    else if (addr_i == A_EDGE)
      rdata_o[NSRC-1:0] = edge_q;
    else if (addr_i >= A_STAT && addr_i < A_STAT + AW'(4*NCORE) && addr_i[1:0] == 2'b00)
      rdata_o[NSRC-1:0] = stat[CIW'((addr_i - A_STAT) >> 2)];
  end

  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((en_q & $past(wv)) == $past(wv)));
  assert_disable_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((en_q & $past(wv)) == '0 && (lat_q & $past(wv)) == '0));
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dis || wr_edge) |=> (($past(lat_q) & ~lat_q) == '0));
  assert_level_no_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_edge |=> ((lat_q & ~edge_q) == '0));
endmodule

// File: tb/lirq_router_tb.sv
module lirq_router_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src = '0;
  logic        we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq;
  int checks = 0, fails = 0;
  logic [31:0] pol_sh = '0, edge_sh = '0;

  lirq_router dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
                     .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(int s, bit e, bit p);
    edge_sh[s] = e; pol_sh[s] = p;
    wr(8'h28, pol_sh); wr(8'h2C, edge_sh);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h20, d); chk("R1 enable", d, 0);
    rd(8'h28, d); chk("R1 polarity", d, 0);
    rd(8'h2C, d); chk("R1 edge", d, 0);
    rd(8'h05, d); chk("R1 route", d, 0);
    chk("R1 irq", {16'h0, irq}, 0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    wr(8'd3, 32'hFFFF_FF21); wr(8'd31, 32'h42);
    rd(8'd3, d);  chk("R2 route 3", d, 32'h21);
    rd(8'd31, d); chk("R2 route 31", d, 32'h42);
    rd(8'd4, d);  chk("R2 route 4 untouched", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(8'h20, 32'hF0); wr(8'h20, 32'h03);
    rd(8'h20, d); chk("R3 set keeps zeros", d, 32'hF3);
    wr(8'h24, 32'h30);
    rd(8'h20, d); chk("R4 clear", d, 32'hC3);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R4 clear all", d, 0);
  endtask

  task automatic t_level_high;
    wr(8'd4, 32'h11); set_mode(4, 0, 1); wr(8'h20, 32'h10);
    cyc(3); chk("R7 idle low", irq[0], 0);
    src[4] = 1;
    cyc(1); chk("R13 level not yet", irq[0], 0);
    cyc(1); chk("R7 R13 level high", irq[0], 1);
    src[4] = 0;
    cyc(2); chk("R7 drops", irq[0], 0);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    wr(8'd9, 32'h22); wr(8'h20, 32'h200);
    chk("R8 low input pending", irq[5], 1);
    rd(8'h34, d); chk("R10 core1 status", d, 32'h200);
    rd(8'h30, d); chk("R10 core0 excludes core1", d, 0);
    src[9] = 1;
    cyc(2); chk("R8 high input idle", irq[5], 0);
  endtask

  task automatic t_rising;
    logic [31:0] d, s;
    wr(8'd12, 32'h84); set_mode(12, 1, 0); wr(8'h20, 32'h1000);
    cyc(3); chk("R5 idle", irq[11], 0);
    src[12] = 1;
    cyc(2); chk("R13 edge not yet", irq[11], 0);
    cyc(1); chk("R5 R13 rising", irq[11], 1);
    src[12] = 0;
    cyc(4); chk("R9 held", irq[11], 1);
    rd(8'h38, s); chk("R10 core2 status", s, 32'h1000);
    wr(8'h24, s);
    chk("R9 cleared by disable", irq[11], 0);
    wr(8'h20, s);
    rd(8'h20, d); chk("R12 re-enabled", d & 32'h1000, 32'h1000);
    cyc(2); chk("R12 no stale edge", irq[11], 0);
    src[12] = 1; cyc(3);
    chk("R12 new edge", irq[11], 1);
    wr(8'h24, 32'h1000); src[12] = 0;
  endtask

  task automatic t_falling;
    src[20] = 1; cyc(4);
    wr(8'd20, 32'h18); set_mode(20, 1, 1); wr(8'h20, 32'h10_0000);
    src[20] = 0; cyc(3); src[20] = 1;
    wr(8'h24, 32'h10_0000); wr(8'h20, 32'h10_0000);
    cyc(4); chk("R6 rising ignored", irq[12], 0);
    src[20] = 0;
    cyc(2); chk("R13 falling not yet", irq[12], 0);
    cyc(1); chk("R6 falling", irq[12], 1);
  endtask

  task automatic t_share;
    logic [31:0] d;
    wr(8'd5, 32'h11); set_mode(5, 0, 1); wr(8'h20, 32'h20);
    src[5] = 1; cyc(2);
    chk("R11 shared line", irq[0], 1);
    rd(8'h30, d); chk("R10 core0 status", d, 32'h20);
    src[4] = 1; cyc(2);
    rd(8'h30, d); chk("R10 two sources", d, 32'h30);
    wr(8'h24, 32'h30);
    chk("R11 disabled sources gated", irq[0], 0);
  endtask

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    t_reset(); t_route(); t_enable(); t_level_high();
    t_level_low(); t_rising(); t_falling(); t_share();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule